// File: doc/BRIEF.md
# Modulating Sine Oscillator

A numerically controlled oscillator that produces one sampled sine value per master clock. A wide phase accumulator advances on every clock by one of two frequency tuning words. One of four phase offsets is added to the upper bits of the accumulator. The sum addresses a quarter-wave sine table. Input pins choose the tuning word and the phase offset, so frequency-shift and phase-shift keying come from toggling pins, with no register writes while the carrier runs.

A host loads the six words over a 16-bit parallel bus with a 3-bit address and an active-low write strobe. Each tuning word is written as two halves. The low half waits in a holding register until the high half arrives, and both halves then take effect together. A synchronous clear restarts the waveform at zero phase. A sleep input freezes the accumulator and parks the output at mid-scale.

Top module: `mod_nco`

## Requirements
- R1: While `rst_n` is low, `sample` reads 0x200. All tuning words, phase offsets, selects and the accumulator are zero.
- R2: On each clock edge with `clr` and `sleep` low, the accumulator adds the active tuning word picked by the registered frequency select, modulo 2^ACC_W. The `sample` register takes S(idx), where idx = (top PH_W bits of the accumulator before that edge + active phase offset picked by the registered phase select) mod 2^PH_W.
- R3: S(p) is offset binary. The quadrant is q = p[PH_W-1:PH_W-2] and the remainder is r = p[PH_W-3:0], with QN = 2^(PH_W-2). The table index is i = r for even q and QN-1-r for odd q. The magnitude is m = floor(511*sin(pi*(2i+1)/(4*QN)) + 0.5). S = 0x200+m for q < 2 and 0x200-m otherwise.
- R4: Address map: 0 and 1 are the low and high halves of tuning word 0. 2 and 3 are the low and high halves of tuning word 1. 4 to 7 are phase offsets 0 to 3, each taking `data[PH_W-1:0]`.
- R5: A low-half write changes only the holding register. The active tuning word is unchanged until the high half of the same word is written. That write makes {high data, held low half} active at the same edge.
- R6: A phase offset write is active from the next clock edge.
- R7: `fsel` is registered. A change at the pins steers the accumulator from the second edge after it. The accumulator is never reset by a switch, so phase stays continuous.
- R8: `psel` is registered in the same way as `fsel`. The new offset appears in `sample` from the second edge.
- R9: While `sleep` is high, the accumulator holds its value and `sample` becomes 0x200. When `sleep` is released, the accumulator resumes from the held value. Register writes still take place during sleep.
- R10: An edge with `clr` high sets the accumulator to zero and `sample` to 0x200, the sine of zero phase.
- R11: A write takes place on every clock edge at which `wr_n` is low. Holding the strobe low for several edges applies each bus value in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe, sampled at each edge |
| addr | input | 3 | Register address |
| data | input | DW | Write data |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| sleep | input | 1 | Freeze accumulator, mid-scale output |
| clr | input | 1 | Synchronous accumulator clear |
| sample | output | OUT_W | Sine sample, offset binary |

## Verification
The bench builds the block with its full defaults: a 32-bit accumulator, a 12-bit table address, 10-bit samples and a 16-bit bus. With a tuning word of 2^20, the table index steps by exactly one per clock. A single clear-and-run pass therefore visits all 4096 phase indices, and every quadrant mirror and sign flip is compared against the arithmetic formula. A cycle-level model in the bench then follows arbitrary tuning words, select toggling, lone low-half writes, sleep and mid-run clears, and every sample is compared on every cycle.

// File: rtl/mod_nco.sv
module mod_nco #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int OUT_W = 10,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic [2:0]       addr,
  input  logic [DW-1:0]    data,
  input  logic             fsel,
  input  logic [1:0]       psel,
  input  logic             sleep,
  input  logic             clr,
  output logic [OUT_W-1:0] sample
);
  localparam int QN  = 1 << (PH_W - 2);
  localparam int HW  = ACC_W - DW;
  localparam int AMP = (1 << (OUT_W - 1)) - 1;
  localparam logic [OUT_W-1:0] MIDV = OUT_W'(1 << (OUT_W - 1));
  localparam real PI = 3.14159265358979323846;

  logic [DW-1:0]    lo_hold [2];
  logic [ACC_W-1:0] fw [2];
  logic [PH_W-1:0]  pw [4];
  logic             fsel_q;
  logic [1:0]       psel_q;
  logic [ACC_W-1:0] acc;
  logic [OUT_W-2:0] qrom [QN];

  for (genvar i = 0; i < QN; i++) begin : g_rom
    localparam int M = int'($floor(real'(AMP) * $sin(PI * real'(2 * i + 1) / real'(4 * QN)) + 0.5));
    assign qrom[i] = M[OUT_W-2:0];
  end

  wire [PH_W-1:0]  idx  = acc[ACC_W-1 -: PH_W] + pw[psel_q];
  wire [1:0]       quad = idx[PH_W-1 -: 2];
  wire [PH_W-3:0]  ridx = quad[0] ? ~idx[PH_W-3:0] : idx[PH_W-3:0];
  wire [OUT_W-1:0] mag  = {1'b0, qrom[ridx]};
  wire [OUT_W-1:0] sine = quad[1] ? MIDV - mag : MIDV + mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        lo_hold[k] <= '0;
        fw[k]      <= '0;
      end
      for (int k = 0; k < 4; k++) pw[k] <= '0;
    end else if (!wr_n) begin
      case (addr)
        3'd0:    lo_hold[0] <= data;
        3'd1:    fw[0] <= {data[HW-1:0], lo_hold[0]};
        3'd2:    lo_hold[1] <= data;
        3'd3:    fw[1] <= {data[HW-1:0], lo_hold[1]};
        default: pw[addr[1:0]] <= data[PH_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= 1'b0;
      psel_q <= '0;
      acc    <= '0;
      sample <= MIDV;
    end else begin
      fsel_q <= fsel;
      psel_q <= psel;
      if (clr) begin
        acc    <= '0;
        sample <= MIDV;
      end else if (sleep) begin
        sample <= MIDV;
      end else begin
        acc    <= acc + fw[fsel_q];
        sample <= sine;
      end
    end
  end

  a_r9_sleep_mid: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> sample == MIDV);
  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !clr) |=> $stable(acc));
  a_r10_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0 && sample == MIDV));
  a_r5_lo_no_commit0: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && addr == 3'd0) |=> $stable(fw[0]));
  a_r5_lo_no_commit1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && addr == 3'd2) |=> $stable(fw[1]));
  a_r7_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> ($stable(fw[0]) && $stable(fw[1])));
endmodule

// File: tb/mod_nco_tb.sv
module mod_nco_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [15:0] data = '0;
  logic        fsel = 1'b0;
  logic [1:0]  psel = '0;
  logic        sleep = 1'b0;
  logic        clr = 1'b0;
  logic [9:0]  sample;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  bit [15:0] m_lo [2];
  bit [31:0] m_f [2];
  int        m_p [4];
  bit        m_fq;
  bit [1:0]  m_pq;
  bit [31:0] m_acc;
  int        m_out = 512;

  always #2.5 clk = ~clk;

  mod_nco #(.ACC_W(32), .PH_W(12), .OUT_W(10), .DW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .data(data),
    .fsel(fsel), .psel(psel), .sleep(sleep), .clr(clr), .sample(sample)
  );

  function automatic int sine_of(int p);
    int q, r, i, m;
    q = (p >> 10) & 3;
    r = p & 1023;
    i = (q & 1) ? 1023 - r : r;
    m = int'($floor(511.0 * $sin(3.14159265358979323846 * real'(2 * i + 1) / 4096.0) + 0.5));
    return (q >= 2) ? 512 - m : 512 + m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_lo[k] = 0; m_f[k] = 0; end
      for (int k = 0; k < 4; k++) m_p[k] = 0;
      m_fq = 0; m_pq = 0; m_acc = 0; m_out = 512;
    end else begin
      int idx;
      bit [31:0] nacc;
      idx = (int'(m_acc >> 20) + m_p[m_pq]) & 4095;
      m_out = (clr || sleep) ? 512 : sine_of(idx);
      nacc = clr ? 32'd0 : (sleep ? m_acc : m_acc + m_f[m_fq]);
      m_acc = nacc;
      if (!wr_n) begin
        case (addr)
          3'd0: m_lo[0] = data;
          3'd1: m_f[0] = {data, m_lo[0]};
          3'd2: m_lo[1] = data;
          3'd3: m_f[1] = {data, m_lo[1]};
          default: m_p[addr[1:0]] = int'(data[11:0]);
        endcase
      end
      m_fq = fsel;
      m_pq = psel;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (chk_on) begin
      checks++;
      if (int'(sample) != m_out) begin
        errors++;
        $display("FAIL %s: sample=%0d expected=%0d at %0t", cur_req, sample, m_out, $time);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(bit [2:0] a, bit [15:0] d);
    wr_n = 1'b0; addr = a; data = d;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic clear_pulse();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    idle(3);
    checks++;
    if (sample != 10'h200) begin
      errors++;
      $display("FAIL R1: reset sample=%0d expected=512", sample);
    end
    rst_n = 1'b1;
    chk_on = 1'b1;
    cur_req = "R1"; idle(5);

    cur_req = "R4";
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0010);
    wr(3'd4, 16'h0000);
    clear_pulse();
    cur_req = "R3"; idle(4100);

    cur_req = "R6";
    wr(3'd6, 16'd1000);
    wr(3'd7, 16'hFFFF);
    psel = 2'd2;
    cur_req = "R8"; idle(40);
    psel = 2'd3; idle(20);
    cur_req = "R6"; wr(3'd7, 16'd77); idle(20);
    psel = 2'd0;

    cur_req = "R4";
    wr(3'd2, 16'h4567);
    wr(3'd3, 16'h0123);
    fsel = 1'b1;
    cur_req = "R2"; idle(200);
    cur_req = "R7";
    for (int k = 0; k < 12; k++) begin fsel = ~fsel; psel = psel + 2'd1; idle(7); end
    fsel = 1'b1;

    cur_req = "R5";
    wr(3'd2, 16'hFFFF); idle(100);
    wr(3'd3, 16'h0800); idle(100);

    cur_req = "R9";
    sleep = 1'b1; idle(30);
    wr(3'd0, 16'h1234); wr(3'd1, 16'h0567); idle(20);
    sleep = 1'b0; fsel = 1'b0; idle(50);

    cur_req = "R10";
    clear_pulse(); idle(30);
    clr = 1'b1; sleep = 1'b1; idle(3);
    clr = 1'b0; sleep = 1'b0; idle(20);

    cur_req = "R11";
    wr_n = 1'b0; addr = 3'd4;
    data = 16'd100; @(negedge clk);
    data = 16'd2100; @(negedge clk);
    addr = 3'd0; data = 16'h0000; @(negedge clk);
    addr = 3'd1; data = 16'h0020; @(negedge clk);
    wr_n = 1'b1;
    idle(100);

    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule